// File: doc/BRIEF.md
# Wildcard String Match Array

A linear systolic array that compares a short pattern, which may contain wild-card positions, against an unbounded text stream. It produces one result bit for each text character. A single character bus feeds the array, carrying pattern and text on alternate clock cycles. Each pattern character arrives with two flags. One marks the final position of the pattern. The other marks a wild-card position, which matches any text character.

The host resends the pattern back to back without pause. A change of pattern is therefore simply a different character sequence on the bus, and no loading phase is needed. Pattern characters travel rightwards one cell per cycle and text characters travel leftwards one cell per cycle. Each cell folds every comparison it sees into a partial result. The cell releases that result onto the leftbound text when the final pattern character passes. Each verdict therefore leaves the left end together with the last text character of the window it judges.

The pattern exits at the right end and the text exits at the left end, and a result stream can be fed in at the right end. Several arrays can therefore be chained into one longer array.

Top module: `wild_match_array`

## Requirements
- R1: For text index i, the result bit that leaves with text character i is 1 exactly when text characters i-K .. i equal pattern characters 0 .. K position by position, where K+1 is the pattern length. Equality compares all CW bits.
- R2: A pattern position whose wild flag is 1 matches every text character value.
- R3: The pattern length is any value from 1 to NCELL. It is set by the end flag, which is 1 on the last pattern character only. The next pattern character on the bus is the first character again.
- R4: Text characters leave the left end (txt_out, txt_out_vld=1) in arrival order. The first text character leaves NCELL cycles after the cycle in which it was on the bus. Each result bit appears on res_out in the same cycle as the text character that closes its window.
- R5: res_out_vld is 0 for text indices below K. Once streaming has run for at least 4·NCELL+2·K text characters, every text character leaves with res_out_vld=1. res_out_vld is never 1 without txt_out_vld.
- R6: A synchronous active-high rst clears pat_out_vld, txt_out_vld and res_out_vld, and makes the next cycle a pattern cycle (pat_beat=1).
- R7: pat_beat alternates every cycle: 1 means the bus is taken as pattern, 0 means it is taken as text. Pattern characters leave the right end with their flags unchanged, in order, NCELL cycles after their bus cycle. pat_out_vld is 1 only in cycles with pat_beat=1, and txt_out_vld is 1 only in cycles with pat_beat=0.
- R8: While no end flag reaches a cell, a bit applied on res_in with res_in_vld=1 in a text cycle travels with that cycle's text character. It leaves unchanged on res_out with res_out_vld=1.
- R9: bus_end and bus_wild are ignored in text cycles. res_in and res_in_vld are ignored in pattern cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat per cycle |
| rst | input | 1 | Synchronous reset, active high |
| bus_chr | input | CW | Shared character bus, pattern or text by phase |
| bus_end | input | 1 | Last-pattern-character flag (pattern cycles) |
| bus_wild | input | 1 | Wild-card flag (pattern cycles) |
| res_in | input | 1 | Result bit entering with text at the right end |
| res_in_vld | input | 1 | res_in carries a result (text cycles) |
| pat_beat | output | 1 | 1: bus is sampled as pattern this cycle |
| pat_out | output | CW | Pattern character leaving the right end |
| pat_out_end | output | 1 | End flag of pat_out |
| pat_out_wild | output | 1 | Wild flag of pat_out |
| pat_out_vld | output | 1 | pat_out holds a character |
| txt_out | output | CW | Text character leaving the left end |
| txt_out_vld | output | 1 | txt_out holds a character |
| res_out | output | 1 | Result bit for txt_out |
| res_out_vld | output | 1 | res_out is a completed result |

## Verification
The assertions assume that reset is held from time zero and that the bus is driven on every cycle without gaps, so that both streams flow continuously once they are started. They also assume that NCELL is even, which lets pattern and text meet in the same cell. The stimulus follows pat_beat on every cycle. It restarts the pattern at its first character after each reset and keeps every pattern between 1 and NCELL characters long. It feeds deliberate garbage into bus_end, bus_wild and res_in in the cycles where those inputs must be ignored.

// File: rtl/wild_match_array.sv
module wild_match_array #(
  parameter int NCELL = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] bus_chr,
  input  logic          bus_end,
  input  logic          bus_wild,
  input  logic          res_in,
  input  logic          res_in_vld,
  output logic          pat_beat,
  output logic [CW-1:0] pat_out,
  output logic          pat_out_end,
  output logic          pat_out_wild,
  output logic          pat_out_vld,
  output logic [CW-1:0] txt_out,
  output logic          txt_out_vld,
  output logic          res_out,
  output logic          res_out_vld
);

  logic             ph;
  logic [CW-1:0]    pc [NCELL];
  logic [CW-1:0]    sc [NCELL];
  logic [NCELL-1:0] pe, pw, pv, sv, rb, rv, acc, live;
  logic [NCELL-1:0] hit, act, emit, put, val, mr, mv;

  always_comb begin
    for (int j = 0; j < NCELL; j++) hit[j] = pw[j] | (pc[j] == sc[j]);
  end

  assign act  = pv & sv;
  assign emit = act & pe;
  assign put  = emit & live;
  assign val  = acc & hit;
  assign mr   = (put & val) | (~put & rb);
  assign mv   = rv | put;

  always_ff @(posedge clk) begin
    pc[0] <= bus_chr;
    pe[0] <= bus_end;
    pw[0] <= bus_wild;
    for (int j = 1; j < NCELL; j++) begin
      pc[j] <= pc[j-1];
      pe[j] <= pe[j-1];
      pw[j] <= pw[j-1];
    end
    sc[NCELL-1] <= bus_chr;
    rb[NCELL-1] <= res_in;
    for (int j = 0; j < NCELL-1; j++) begin
      sc[j] <= sc[j+1];
      rb[j] <= mr[j+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 1'b0;
      pv   <= '0;
      sv   <= '0;
      rv   <= '0;
      acc  <= '1;
      live <= '0;
    end else begin
      ph          <= ~ph;
      pv          <= {pv[NCELL-2:0], ~ph};
      sv          <= {ph, sv[NCELL-1:1]};
      rv          <= {ph & res_in_vld, mv[NCELL-1:1]};
      for (int j = 0; j < NCELL; j++) begin
        if (act[j]) begin
          if (pe[j]) begin
            acc[j]  <= 1'b1;
            live[j] <= 1'b1;
          end else begin
            acc[j]  <= val[j];
          end
        end
      end
    end
  end

  assign pat_beat     = ~ph;
  assign pat_out      = pc[NCELL-1];
  assign pat_out_end  = pe[NCELL-1];
  assign pat_out_wild = pw[NCELL-1];
  assign pat_out_vld  = pv[NCELL-1];
  assign txt_out      = sc[0];
  assign txt_out_vld  = sv[0];
  assign res_out      = mr[0];
  assign res_out_vld  = mv[0] & sv[0];

endmodule

// File: rtl/wild_match_chk.sv
module wild_match_chk (
  input logic clk,
  input logic rst,
  input logic pat_beat,
  input logic pat_out_vld,
  input logic txt_out_vld,
  input logic res_out_vld
);

  a_r7_beat_toggle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pat_beat != $past(pat_beat));

  a_r7_pat_out_phase: assert property (@(posedge clk) disable iff (rst)
    pat_out_vld |-> pat_beat);

  a_r4_txt_out_phase: assert property (@(posedge clk) disable iff (rst)
    txt_out_vld |-> !pat_beat);

  a_r5_res_with_txt: assert property (@(posedge clk) disable iff (rst)
    res_out_vld |-> txt_out_vld);

  a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pat_out_vld && !txt_out_vld && !res_out_vld && pat_beat));

  a_r7_pat_out_gap: assert property (@(posedge clk) disable iff (rst)
    pat_out_vld |=> !pat_out_vld);

endmodule

bind wild_match_array wild_match_chk u_chk (
  .clk(clk),
  .rst(rst),
  .pat_beat(pat_beat),
  .pat_out_vld(pat_out_vld),
  .txt_out_vld(txt_out_vld),
  .res_out_vld(res_out_vld)
);

// File: tb/wild_match_array_tb_top.sv
module wild_match_array_tb_top;
  localparam int N = 8;
  localparam int W = 4;
  localparam int NOUT = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [W-1:0] bus_chr = '0;
  logic bus_end = 1'b0, bus_wild = 1'b0, res_in = 1'b0, res_in_vld = 1'b0;
  logic pat_beat, pat_out_end, pat_out_wild, pat_out_vld, txt_out_vld, res_out, res_out_vld;
  logic [W-1:0] pat_out, txt_out;

  wild_match_array #(.NCELL(N), .CW(W)) dut_i (
    .clk(clk), .rst(rst), .bus_chr(bus_chr), .bus_end(bus_end), .bus_wild(bus_wild),
    .res_in(res_in), .res_in_vld(res_in_vld), .pat_beat(pat_beat), .pat_out(pat_out),
    .pat_out_end(pat_out_end), .pat_out_wild(pat_out_wild), .pat_out_vld(pat_out_vld),
    .txt_out(txt_out), .txt_out_vld(txt_out_vld), .res_out(res_out), .res_out_vld(res_out_vld)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic [31:0] pat;
    logic [7:0]  wild;
    logic [3:0]  amask;
    logic [7:0]  seed;
  } case_t;

  localparam case_t CASES [6] = '{
    '{3'd2, 32'h0000_0301, 8'h02, 4'h3, 8'd17},
    '{3'd0, 32'h0000_0002, 8'h00, 4'h3, 8'd5},
    '{3'd3, 32'h0000_2121, 8'h00, 4'h3, 8'd99},
    '{3'd7, 32'h0100_1101, 8'h84, 4'h1, 8'd42},
    '{3'd4, 32'h0000_0000, 8'h1F, 4'h3, 8'd7},
    '{3'd1, 32'h0000_00FF, 8'h00, 4'hF, 8'd200}
  };

  int checks = 0, fails = 0;
  logic [W-1:0] txt [128];
  case_t cur;
  int k, cyc, pq, ti, oi, po, first_p, first_t, case_fails;
  bit pass_mode;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      case_fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d, text %0d)", req, act, exp, cyc, oi);
    end
  endtask

  function automatic bit exp_res(input int i);
    if (i < k) return 1'b0;
    for (int m = 0; m <= k; m++)
      if (!cur.wild[m] && txt[(i-k+m) & 127] != cur.pat[4*m +: 4]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit rbit(input int i);
    return (i % 3 == 0) || (i % 5 == 1);
  endfunction

  task automatic load_case(input case_t c);
    logic [7:0] x;
    cur = c;
    k = int'(c.k);
    x = c.seed;
    for (int i = 0; i < 128; i++) begin
      x = x * 8'd37 + 8'd11;
      txt[i] = x[6:3] & c.amask;
    end
  endtask

  task automatic start();
    rst = 1'b1;
    res_in_vld = 1'b1;
    bus_end = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pat_out_vld && !txt_out_vld && !res_out_vld, "R6 valids in reset",
        int'({pat_out_vld, txt_out_vld, res_out_vld}), 0);
    chk(pat_beat == 1'b1, "R6 first phase is pattern", int'(pat_beat), 1);
    rst = 1'b0;
    cyc = 0; pq = 0; ti = 0; oi = 0; po = 0; first_p = -1; first_t = -1; case_fails = 0;
  endtask

  task automatic sample();
    string tag;
    if (pat_out_vld) begin
      if (first_p < 0) first_p = cyc;
      chk(pat_out == cur.pat[4*po +: 4], "R7 pattern out char", int'(pat_out), int'(cur.pat[4*po +: 4]));
      chk(pat_out_end == (!pass_mode && po == k), "R7 pattern out end flag", int'(pat_out_end), int'(!pass_mode && po == k));
      chk(pat_out_wild == cur.wild[po], "R7 pattern out wild flag", int'(pat_out_wild), int'(cur.wild[po]));
      po = (po == k) ? 0 : po + 1;
    end
    if (txt_out_vld) begin
      if (first_t < 0) first_t = cyc;
      chk(txt_out == txt[oi & 127], "R4 text order", int'(txt_out), int'(txt[oi & 127]));
      if (pass_mode) begin
        chk(res_out_vld && res_out == rbit(oi), "R8 result pass-through",
            int'({res_out_vld, res_out}), int'({1'b1, rbit(oi)}));
      end else begin
        if (oi < k) chk(!res_out_vld, "R5 no result before full window", int'(res_out_vld), 0);
        else if (oi >= 4*N + 2*k) chk(res_out_vld, "R5 result valid when streaming", int'(res_out_vld), 1);
        // R3 exercised by the one-character and full-length cases
        tag = (cur.wild != 0) ? "R2" : ((k == 0 || k == N-1) ? "R3" : "R1");
        if (res_out_vld) chk(res_out == exp_res(oi), tag, int'(res_out), int'(exp_res(oi)));
      end
      oi++;
    end
  endtask

  task automatic drive();
    if (pat_beat) begin
      bus_chr = cur.pat[4*pq +: 4];
      bus_end = !pass_mode && (pq == k);
      bus_wild = cur.wild[pq];
      res_in = cyc[1];
      res_in_vld = 1'b1;
      pq = (pq == k) ? 0 : pq + 1;
    end else begin
      bus_chr = txt[ti & 127];
      bus_end = cyc[2];
      bus_wild = cyc[1] ^ cyc[3];
      res_in = pass_mode ? rbit(ti) : cyc[2];
      res_in_vld = pass_mode;
      ti++;
    end
  endtask

  task automatic run();
    while (oi < NOUT && cyc < 4000) begin
      sample();
      drive();
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    pass_mode = 1'b0;
    foreach (CASES[c]) begin
      load_case(CASES[c]);
      start();
      run();
      chk(case_fails == 0, "R9 ignored inputs left results intact", case_fails, 0);
      if (c == 0) begin
        chk(first_p == N, "R7 pattern exit latency", first_p, N);
        chk(first_t == N + 1, "R4 text exit latency", first_t, N + 1);
      end
    end
    pass_mode = 1'b1;
    load_case(CASES[2]);
    start();
    run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule